// File: doc/BRIEF.md
# Memory Interface Calibration Stage Sequencer

After reset, this block steps a memory physical layer through its calibration stages in a fixed order. Each stage has a 5-bit code from 0x00 to 0x14. The block starts one stage at a time with a one-cycle start pulse and then waits for the stage engine to answer with done or error. The training algorithms themselves sit in external engines. This block only orders them, repeats the rank-wise stages over the ranks, and keeps track of how far calibration has got.

Two inputs shape the sequence:
- A module-type input selects buffered-module operation. In that mode the data-buffer training stages (0x02 to 0x07) are added, and the whole module counts as one endpoint.
- An enable mask removes stages that the configuration does not need.

A bypass input jumps straight to the completed state for fast simulation. Any error or timeout stops the sequence with a sticky failure. The failing stage and rank are held on the outputs until the next reset.

Top module: `calseq_top`

## Requirements
- R1: During and right after synchronous reset, `stage_start`, `cal_complete` and `cal_failed` are 0, `stage_code` is 0x00 and `stage_err_status` is all zeros.
- R2: Launches happen in strictly ascending stage-code order. Stage 0x00 is launched first and stage 0x01 second, before any other stage.
- R3: Stages 0x02 to 0x07 are launched only when `lrdimm_mode` is 1. When it is 0 they are skipped without a start pulse.
- R4: Sequential stages are 0x02 to 0x09, 0x0C and 0x10. With `lrdimm_mode` at 0, each is launched `NUM_RANKS` times with `stage_rank` running 0, 1, … up to `NUM_RANKS`-1, and `stage_all_ranks` is 0 on each launch.
- R5: Parallel stages are 0x0A, 0x0B, 0x0D, 0x0E, 0x0F, 0x11 and 0x13. Each is launched once with `stage_rank`=0 and `stage_all_ranks`=1.
- R6: Stages 0x00, 0x01 and 0x12 are launched once with `stage_rank`=0 and `stage_all_ranks`=0.
- R7: With `lrdimm_mode` at 1, each sequential stage is launched exactly once, at rank 0.
- R8: A 0 in `stage_en_mask[i]` removes stage i, and it gets no start pulse. Mask bits 0, 1 and 20 have no effect.
- R9: Stage 0x14 gets no handshake. After the last earlier stage finishes, `stage_code` becomes 0x14 and `cal_complete` rises. `cal_complete` then stays high until reset.
- R10: If `cal_bypass` is 1 when the first stage would be chosen, no stage is launched. `stage_code` becomes 0x14 and `cal_complete` is 1 one cycle after reset is released.
- R11: An asserted `stage_error` while waiting stops the sequence. `cal_failed` becomes 1 and stays 1. `err_stage` and `err_rank` hold the failing launch's code and rank. `stage_err_status` has only bit `err_stage` set. `cal_complete` stays 0, and no further start pulse occurs.
- R12: A done presented n cycles after the start cycle is accepted for 1 ≤ n ≤ `timeout_limit`+1. If no done or error arrives, `cal_failed` is 1 from cycle `timeout_limit`+2 after the start cycle, and that stage and rank are recorded as in R11.
- R13: `stage_start` is high for exactly one cycle per launch. `stage_code` and `stage_rank` stay unchanged in the cycle that follows a launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lrdimm_mode | input | 1 | 1 selects buffered-module operation (data-buffer stages on, single endpoint) |
| stage_en_mask | input | 21 | Per-stage enable, bit i for stage code i |
| cal_bypass | input | 1 | Skip all stages and report completion |
| timeout_limit | input | TMO_W | Number of wait cycles allowed before a timeout |
| stage_done | input | 1 | Stage engine finished the current launch |
| stage_error | input | 1 | Stage engine failed the current launch |
| stage_start | output | 1 | One-cycle launch pulse |
| stage_code | output | 5 | Current stage code |
| stage_rank | output | RANK_W | Rank for the current launch |
| stage_all_ranks | output | 1 | Current launch covers all ranks |
| cal_complete | output | 1 | Calibration finished; memory traffic allowed |
| cal_failed | output | 1 | Sticky failure flag |
| err_stage | output | 5 | Stage code of the failed launch |
| err_rank | output | RANK_W | Rank of the failed launch |
| stage_err_status | output | 21 | Per-stage error bits |

## Verification
The properties assume that `lrdimm_mode`, `stage_en_mask` and `cal_bypass` stay fixed from reset until the sequence ends. They also assume that a stage engine answers only after it has seen a start pulse. The bench meets both assumptions: it sets the configuration only while reset is asserted, and its responder drives done or error for a single cycle, at least one cycle after the start pulse, and only for the launch that pulse started.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

    localparam int STAGE_W   = 5;
    localparam int N_STAGES  = 21;
    localparam logic [STAGE_W-1:0] CODE_LAST = 5'h14;

    typedef enum logic [1:0] {
        K_ONCE = 2'd0,
        K_SEQ  = 2'd1,
        K_PAR  = 2'd2
    } stage_kind_e;

    typedef enum logic [2:0] {
        S_SEL    = 3'd0,
        S_LAUNCH = 3'd1,
        S_WAIT   = 3'd2,
        S_DONE   = 3'd3,
        S_FAIL   = 3'd4
    } seq_state_e;

    function automatic stage_kind_e stage_kind(input logic [STAGE_W-1:0] code);
        case (code)
            5'h00, 5'h01, 5'h12, 5'h14: return K_ONCE;
            5'h0A, 5'h0B, 5'h0D, 5'h0E,
            5'h0F, 5'h11, 5'h13:        return K_PAR;
            default:                    return K_SEQ;
        endcase
    endfunction

    function automatic logic is_buffer_stage(input logic [STAGE_W-1:0] code);
        return (code >= 5'h02) && (code <= 5'h07);
    endfunction

    function automatic logic is_mandatory(input logic [STAGE_W-1:0] code);
        return (code == 5'h00) || (code == 5'h01) || (code == CODE_LAST);
    endfunction

endpackage

// File: rtl/calseq_pick.sv
module calseq_pick
    import calseq_pkg::*;
(
    input  logic [STAGE_W-1:0]  from_code,
    input  logic                lrdimm_mode,
    input  logic [N_STAGES-1:0] stage_en_mask,
    output logic [STAGE_W-1:0]  next_code
);
    logic [N_STAGES-1:0] runnable;

    for (genvar g = 0; g < N_STAGES; g++) begin : g_run
        localparam logic [STAGE_W-1:0] CODE = STAGE_W'(g);
        assign runnable[g] = is_mandatory(CODE) ||
                             (stage_en_mask[g] && (lrdimm_mode || !is_buffer_stage(CODE)));
    end

    always_comb begin
        next_code = CODE_LAST;
        for (int i = N_STAGES - 1; i >= 0; i--) begin
            if (runnable[i] && (i >= int'(from_code)))
                next_code = STAGE_W'(i);
        end
    end
endmodule

// File: rtl/calseq_timer.sv
module calseq_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && (cnt != limit))
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == limit);
endmodule

// File: rtl/calseq_errlog.sv
module calseq_errlog
    import calseq_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic [STAGE_W-1:0]  code_in,
    input  logic [RANK_W-1:0]   rank_in,
    output logic [STAGE_W-1:0]  err_stage,
    output logic [RANK_W-1:0]   err_rank,
    output logic [N_STAGES-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_stage <= '0;
            err_rank  <= '0;
        end else if (capture) begin
            err_stage <= code_in;
            err_rank  <= rank_in;
        end
    end

    for (genvar g = 0; g < N_STAGES; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[g] <= 1'b0;
            else if (capture && (int'(code_in) == g))
                status[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/calseq_top.sv
module calseq_top
    import calseq_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int TMO_W     = 16,
    localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lrdimm_mode,
    input  logic [N_STAGES-1:0] stage_en_mask,
    input  logic                cal_bypass,
    input  logic [TMO_W-1:0]    timeout_limit,
    input  logic                stage_done,
    input  logic                stage_error,
    output logic                stage_start,
    output logic [STAGE_W-1:0]  stage_code,
    output logic [RANK_W-1:0]   stage_rank,
    output logic                stage_all_ranks,
    output logic                cal_complete,
    output logic                cal_failed,
    output logic [STAGE_W-1:0]  err_stage,
    output logic [RANK_W-1:0]   err_rank,
    output logic [N_STAGES-1:0] stage_err_status
);
    localparam logic [RANK_W-1:0] RANK_MAX = RANK_W'(NUM_RANKS - 1);

    seq_state_e         state;
    logic [STAGE_W-1:0] cur_code;
    logic [RANK_W-1:0]  cur_rank;
    logic [STAGE_W-1:0] next_code;
    stage_kind_e        kind;
    logic               waiting;
    logic               expired;
    logic               timed_out;
    logic               fail_now;
    logic               more_ranks;

    calseq_pick u_pick (
        .from_code     (cur_code),
        .lrdimm_mode   (lrdimm_mode),
        .stage_en_mask (stage_en_mask),
        .next_code     (next_code)
    );

    calseq_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == S_LAUNCH),
        .run     (waiting),
        .limit   (timeout_limit),
        .expired (expired)
    );

    assign kind       = stage_kind(cur_code);
    assign waiting    = (state == S_WAIT);
    assign timed_out  = expired && !stage_done && !stage_error;
    assign fail_now   = waiting && (stage_error || timed_out);
    assign more_ranks = (kind == K_SEQ) && !lrdimm_mode && (cur_rank != RANK_MAX);

    calseq_errlog #(.RANK_W(RANK_W)) u_errlog (
        .clk       (clk),
        .rst       (rst),
        .capture   (fail_now),
        .code_in   (cur_code),
        .rank_in   (cur_rank),
        .err_stage (err_stage),
        .err_rank  (err_rank),
        .status    (stage_err_status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_SEL;
            cur_code <= '0;
            cur_rank <= '0;
        end else begin
            case (state)
                S_SEL: begin
                    cur_rank <= '0;
                    if (cal_bypass) begin
                        cur_code <= CODE_LAST;
                        state    <= S_DONE;
                    end else begin
                        cur_code <= next_code;
                        state    <= (next_code == CODE_LAST) ? S_DONE : S_LAUNCH;
                    end
                end
                S_LAUNCH: state <= S_WAIT;
                S_WAIT: begin
                    if (fail_now) begin
                        state <= S_FAIL;
                    end else if (stage_done) begin
                        if (more_ranks) begin
                            cur_rank <= cur_rank + 1'b1;
                            state    <= S_LAUNCH;
                        end else begin
                            cur_code <= cur_code + 1'b1;
                            state    <= S_SEL;
                        end
                    end
                end
                S_DONE:  state <= S_DONE;
                S_FAIL:  state <= S_FAIL;
                default: state <= S_FAIL;
            endcase
        end
    end

    assign stage_start     = (state == S_LAUNCH);
    assign stage_code      = cur_code;
    assign stage_rank      = cur_rank;
    assign stage_all_ranks = (kind == K_PAR);
    assign cal_complete    = (state == S_DONE);
    assign cal_failed      = (state == S_FAIL);
endmodule

// File: rtl/calseq_checker.sv
module calseq_checker #(
    parameter int RANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              lrdimm_mode,
    input logic              stage_start,
    input logic [4:0]        stage_code,
    input logic [RANK_W-1:0] stage_rank,
    input logic              stage_all_ranks,
    input logic              cal_complete,
    input logic              cal_failed,
    input logic [4:0]        err_stage,
    input logic [RANK_W-1:0] err_rank
);
    a_r13_start_pulse: assert property (@(posedge clk) disable iff (rst)
        stage_start |=> !stage_start);

    a_r13_hold_target: assert property (@(posedge clk) disable iff (rst)
        stage_start |=> ($stable(stage_code) && $stable(stage_rank)));

    a_r3_no_buffer_stage: assert property (@(posedge clk) disable iff (rst)
        (stage_start && !lrdimm_mode) |-> !((stage_code >= 5'h02) && (stage_code <= 5'h07)));

    a_r7_single_endpoint: assert property (@(posedge clk) disable iff (rst)
        (stage_start && lrdimm_mode) |-> (stage_rank == '0));

    a_r5_parallel_rank0: assert property (@(posedge clk) disable iff (rst)
        (stage_start && stage_all_ranks) |-> (stage_rank == '0));

    a_r9_complete_sticky: assert property (@(posedge clk) disable iff (rst)
        cal_complete |=> (cal_complete && (stage_code == 5'h14)));

    a_r9_complete_excl: assert property (@(posedge clk) disable iff (rst)
        cal_complete |-> (!cal_failed && !stage_start));

    a_r11_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        cal_failed |=> (cal_failed && $stable(err_stage) && $stable(err_rank)));

    a_r11_no_start_after_fail: assert property (@(posedge clk) disable iff (rst)
        cal_failed |-> !stage_start);
endmodule

bind calseq_top calseq_checker #(.RANK_W(RANK_W)) u_calseq_chk (
    .clk             (clk),
    .rst             (rst),
    .lrdimm_mode     (lrdimm_mode),
    .stage_start     (stage_start),
    .stage_code      (stage_code),
    .stage_rank      (stage_rank),
    .stage_all_ranks (stage_all_ranks),
    .cal_complete    (cal_complete),
    .cal_failed      (cal_failed),
    .err_stage       (err_stage),
    .err_rank        (err_rank)
);

// File: tb/calseq_top_bench.sv
module calseq_top_bench;
    localparam int NR = 4;
    localparam int RW = 2;
    localparam int TW = 16;
    localparam int LIM = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lrdimm_mode = 1'b0;
    logic [20:0]   stage_en_mask = '1;
    logic          cal_bypass = 1'b0;
    logic [TW-1:0] timeout_limit = TW'(LIM);
    logic          stage_done = 1'b0;
    logic          stage_error = 1'b0;
    logic          stage_start;
    logic [4:0]    stage_code;
    logic [RW-1:0] stage_rank;
    logic          stage_all_ranks;
    logic          cal_complete;
    logic          cal_failed;
    logic [4:0]    err_stage;
    logic [RW-1:0] err_rank;
    logic [20:0]   stage_err_status;

    always #2.5 clk = ~clk;

    calseq_top #(.NUM_RANKS(NR), .TMO_W(TW)) u_calseq_top (
        .clk(clk), .rst(rst), .lrdimm_mode(lrdimm_mode), .stage_en_mask(stage_en_mask),
        .cal_bypass(cal_bypass), .timeout_limit(timeout_limit), .stage_done(stage_done),
        .stage_error(stage_error), .stage_start(stage_start), .stage_code(stage_code),
        .stage_rank(stage_rank), .stage_all_ranks(stage_all_ranks),
        .cal_complete(cal_complete), .cal_failed(cal_failed), .err_stage(err_stage),
        .err_rank(err_rank), .stage_err_status(stage_err_status)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    int starts_seen = 0;

    int exp_code [128];
    int exp_rank [128];
    int exp_all  [128];
    int n_exp;
    int got_code [128];
    int got_rank [128];
    int got_all  [128];
    int n_got;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (stage_start) starts_seen++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Expected sequence built from the requirement tables, not from the RTL.
    function automatic int kind_of(input int c);
        if (c == 0 || c == 1 || c == 18) return 0;
        if (c == 10 || c == 11 || c == 13 || c == 14 || c == 15 || c == 17 || c == 19) return 2;
        return 1;
    endfunction

    task automatic build_exp(input bit lrd, input logic [20:0] mask);
        n_exp = 0;
        for (int c = 0; c < 20; c++) begin
            bit runs;
            runs = (c < 2) || (mask[c] && (lrd || c < 2 || c > 7));
            if (runs) begin
                if (kind_of(c) == 1 && !lrd) begin
                    for (int r = 0; r < NR; r++) begin
                        exp_code[n_exp] = c; exp_rank[n_exp] = r; exp_all[n_exp] = 0; n_exp++;
                    end
                end else begin
                    exp_code[n_exp] = c; exp_rank[n_exp] = 0;
                    exp_all[n_exp] = (kind_of(c) == 2) ? 1 : 0; n_exp++;
                end
            end
        end
    endtask

    task automatic do_reset(input bit lrd, input logic [20:0] mask, input bit byp);
        @(negedge clk);
        rst = 1'b1;
        lrdimm_mode = lrd;
        stage_en_mask = mask;
        cal_bypass = byp;
        stage_done = 1'b0;
        stage_error = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs a calibration; err_idx / hang_idx pick a launch to fail (-1 = none).
    task automatic run_cal(input bit lrd, input logic [20:0] mask,
                           input int err_idx, input int hang_idx, input int fixed_dly);
        int guard;
        do_reset(lrd, mask, 1'b0);
        n_got = 0;
        guard = 0;
        forever begin
            if (cal_complete || cal_failed || guard > 5000) break;
            if (stage_start) begin
                int idx;
                int dly;
                idx = n_got;
                if (n_got < 128) begin
                    got_code[n_got] = stage_code;
                    got_rank[n_got] = stage_rank;
                    got_all[n_got]  = stage_all_ranks;
                end
                n_got++;
                if (idx == hang_idx) begin
                    repeat (LIM + 1) @(negedge clk);
                    chk(!cal_failed, "R12", "no failure at limit+1", cal_failed, 0);
                    @(negedge clk);
                    chk(cal_failed, "R12", "failure at limit+2", cal_failed, 1);
                    break;
                end
                dly = (fixed_dly > 0) ? fixed_dly : 1 + (idx % 3);
                repeat (dly) @(negedge clk);
                if (idx == err_idx) stage_error = 1'b1;
                else stage_done = 1'b1;
                @(negedge clk);
                stage_error = 1'b0;
                stage_done = 1'b0;
            end else begin
                @(negedge clk);
                guard++;
            end
        end
    endtask

    task automatic compare_launches(input string tag);
        int lim;
        chk(n_got == n_exp, tag, "launch count", n_got, n_exp);
        lim = (n_got < n_exp) ? n_got : n_exp;
        for (int i = 0; i < lim; i++) begin
            string req;
            req = (exp_code[i] < 2) ? "R2" : (exp_code[i] <= 7) ? "R3" :
                  (kind_of(exp_code[i]) == 2) ? "R5" :
                  (kind_of(exp_code[i]) == 0) ? "R6" : (lrdimm_mode ? "R7" : "R4");
            chk(got_code[i] == exp_code[i] && got_rank[i] == exp_rank[i] && got_all[i] == exp_all[i],
                req, $sformatf("%s launch %0d code/rank/all", tag, i),
                got_code[i] * 256 + got_rank[i] * 16 + got_all[i],
                exp_code[i] * 256 + exp_rank[i] * 16 + exp_all[i]);
        end
    endtask

    initial begin
        logic [20:0] masks [8];
        int s0;
        masks[0] = '1;
        masks[1] = '0;
        masks[2] = 21'h0AAAAA;
        masks[3] = 21'h155555;
        masks[4] = 21'h1FFFFF & ~21'h000104;
        masks[5] = 21'h1FFFFF & ~21'h010300;
        masks[6] = 21'h1FFFFF & ~21'h0A5000;
        masks[7] = 21'h000003;

        // R1: reset state
        do_reset(1'b0, '1, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        chk(!stage_start && !cal_complete && !cal_failed, "R1", "flags in reset",
            {stage_start, cal_complete, cal_failed}, 0);
        chk(stage_code == 0 && stage_err_status == 0, "R1", "code/status in reset",
            {stage_code, stage_err_status}, 0);

        // R2..R9 sweep over module type and enable masks
        for (int l = 0; l < 2; l++) begin
            for (int m = 0; m < 8; m++) begin
                build_exp(l[0], masks[m]);
                run_cal(l[0], masks[m], -1, -1, 0);
                compare_launches($sformatf("R8 lrd%0d mask%0d", l, m));
                chk(cal_complete && !cal_failed, "R9", "complete after last stage",
                    {cal_complete, cal_failed}, 2);
                chk(stage_code == 5'h14, "R9", "final code", stage_code, 5'h14);
                s0 = starts_seen;
                repeat (4) @(negedge clk);
                chk(cal_complete && starts_seen == s0, "R9", "complete sticky, no start",
                    starts_seen - s0, 0);
            end
        end

        // R10: bypass
        do_reset(1'b0, '1, 1'b1);
        s0 = starts_seen;
        @(negedge clk);
        chk(cal_complete && stage_code == 5'h14, "R10", "bypass complete after one cycle",
            {cal_complete, stage_code}, {1'b1, 5'h14});
        repeat (5) @(negedge clk);
        chk(starts_seen == s0 && cal_complete, "R10", "bypass launches nothing",
            starts_seen - s0, 0);

        // R11: error injection, plain and buffered
        for (int t = 0; t < 2; t++) begin
            int ei;
            ei = (t == 0) ? 12 : 5;
            build_exp(t[0], '1);
            run_cal(t[0], '1, ei, -1, 0);
            chk(cal_failed && !cal_complete, "R11", "failed after error",
                {cal_failed, cal_complete}, 2);
            chk(err_stage == exp_code[ei] && err_rank == exp_rank[ei], "R11", "error code/rank",
                {err_stage, err_rank}, {exp_code[ei][4:0], exp_rank[ei][RW-1:0]});
            chk(stage_err_status == (21'd1 << exp_code[ei]), "R11", "error status bits",
                stage_err_status, 21'd1 << exp_code[ei]);
            s0 = starts_seen;
            repeat (10) @(negedge clk);
            chk(cal_failed && !cal_complete && starts_seen == s0, "R11", "halted and sticky",
                starts_seen - s0, 0);
        end

        // R12: done at the latest accepted cycle
        build_exp(1'b0, '1);
        run_cal(1'b0, '1, -1, -1, LIM + 1);
        chk(cal_complete && !cal_failed, "R12", "late done accepted",
            {cal_complete, cal_failed}, 2);
        chk(n_got == n_exp, "R12", "late done launch count", n_got, n_exp);

        // R12: no response at all
        build_exp(1'b0, '1);
        run_cal(1'b0, '1, -1, 7, 0);
        chk(err_stage == exp_code[7] && err_rank == exp_rank[7], "R12", "timeout code/rank",
            {err_stage, err_rank}, {exp_code[7][4:0], exp_rank[7][RW-1:0]});
        chk(stage_err_status == (21'd1 << exp_code[7]), "R12", "timeout status",
            stage_err_status, 21'd1 << exp_code[7]);

        // R13: pulse width (counted) on a short run
        build_exp(1'b1, 21'h000003);
        s0 = starts_seen;
        run_cal(1'b1, 21'h000003, -1, -1, 2);
        chk(starts_seen - s0 == n_exp, "R13", "one start cycle per launch",
            starts_seen - s0, n_exp);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule